// File: doc/BRIEF.md
# I2C Slave to Control-Packet Bridge

The block sits on the local end of a serial control link and acts as an I2C-compatible slave. A local master addresses it with a 7-bit device address, names a register, and then either writes data bytes or, after a repeated START, reads them back. Each write transfer is buffered in full and then issued on a byte-stream packet output as one addressed packet: a sync byte, the device byte with the R/W bit, the register, a byte count, and the payload. Each read byte becomes a one-byte request packet. While the remote answer is pending, the bridge holds SCL low.

SCL and SDA are open-drain. The block never drives a high level: its outputs are pull-down enables, and a released line is pulled high from outside. Both inputs pass through a two-flop synchronizer and a majority-free agreement filter before START, STOP and clock edges are decoded. A configuration input decides whether acknowledges are withheld while the forward link reports no lock.

Top module: `i2c_pb_bridge`

## Requirements
- R1: After reset both pull-down enables are low and `pkt_valid_o` is low.
- R2: `sda_oe_o` changes only while SCL is low.
- R3: The address byte is acknowledged only when its upper 7 bits equal `DEV_ADDR`. On a mismatch SDA stays released for the acknowledge bit, the rest of the transfer up to STOP is ignored, and no packet is sent.
- R4: With `ack_gate_i` low, bytes are acknowledged whatever `link_lock_i` is. With `ack_gate_i` high and `link_lock_i` low, no address, register or data byte is acknowledged and no packet is sent.
- R5: A STOP or repeated START after one or more acknowledged write data bytes sends, one byte per cycle with `pkt_valid_o` high, the bytes `SYNC` (default 8'h79), `{DEV_ADDR,1'b0}`, register, count, and then the data in arrival order. That is 4+count bytes in all.
- R6: Up to `DEPTH` (default 16) data bytes are acknowledged and buffered. Any further byte is not acknowledged and is not sent, and the count byte reads `DEPTH`.
- R7: A write that carries a register byte but no data bytes sends no packet.
- R8: An acknowledged address byte with R/W=1 sends `SYNC`, `{DEV_ADDR,1'b1}`, the last written register, and count 8'h01. SCL is then held low until the reply arrives.
- R9: A reply byte on `rep_valid_i`/`rep_data_i` releases SCL and is shifted out MSB first. A master ACK makes the bridge request register+1 and stretch again. A master NACK ends the read.
- R10: If no reply arrives within `TIMEOUT` cycles, SCL is released and 8'hFF is returned.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` (default 3) clock samples has no effect on the decoded transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| link_lock_i | input | 1 | Forward link locked |
| ack_gate_i | input | 1 | Withhold acknowledges while unlocked |
| pkt_valid_o | output | 1 | Packet byte valid |
| pkt_data_o | output | 8 | Packet byte |
| rep_valid_i | input | 1 | Reply byte valid (read data) |
| rep_data_i | input | 8 | Reply byte |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except at START and STOP. They also assume that the master never issues a STOP or repeated START while the bridge is pulling SDA low, and that the next transfer does not start within the few cycles a packet takes to drain. The stimulus runs a quarter-period of 16 clocks, which is well above the filter and synchronizer delay. It always waits for SCL to read high before it counts the high phase, and it leaves long gaps between transfers. The glitch case inserts 2-sample SCL dips inside the high phase, which keeps them shorter than the filter length.

// File: rtl/i2c_pb_pkg.sv
package i2c_pb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_WDAT, ST_RWAIT, ST_RDAT, ST_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_pb_filt.sv
module i2c_pb_filt #(
  parameter int LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [1:0]     sync_q;
  logic [LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      out_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], in_i};
      hist_q <= {hist_q[LEN-2:0], sync_q[1]};
      if (&hist_q)       out_o <= 1'b1;
      else if (~|hist_q) out_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_pb_fifo.sv
module i2c_pb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  assign dout_o = mem_q[rp_q];
  assign full_o = (cnt_o == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) if (push_i) mem_q[wp_q] <= din_i;

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_o != '0);
endmodule

// File: rtl/i2c_pb_tx.sv
module i2c_pb_tx #(
  parameter int         CW   = 5,
  parameter logic [7:0] SYNC = 8'h79,
  parameter logic [6:0] DEV  = 7'h48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_wr_i,
  input  logic          req_rd_i,
  input  logic [7:0]    reg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [7:0]    fifo_d_i,
  output logic          pop_o,
  output logic          vld_o,
  output logic [7:0]    dat_o
);
  localparam int IW = CW + 1;
  logic          busy_q, rw_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    reg_q;
  logic [CW-1:0] n_q;
  logic [7:0]    sel;
  logic [IW-1:0] last;

  always_comb begin
    case (idx_q)
      IW'(0):  sel = SYNC;
      IW'(1):  sel = {DEV, rw_q};
      IW'(2):  sel = reg_q;
      IW'(3):  sel = 8'(n_q);
      default: sel = fifo_d_i;
    endcase
  end
  assign last  = rw_q ? IW'(3) : IW'(3) + IW'(n_q);
  assign pop_o = busy_q && !rw_q && (idx_q >= IW'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; rw_q <= 1'b0; idx_q <= '0;
      reg_q  <= '0;   n_q  <= '0;
      vld_o  <= 1'b0; dat_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (!busy_q) begin
        if (req_wr_i || req_rd_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          rw_q   <= req_rd_i;
          reg_q  <= reg_i;
          n_q    <= req_rd_i ? CW'(1) : cnt_i;
        end
      end else begin
        vld_o <= 1'b1;
        dat_o <= sel;
        idx_q <= idx_q + 1'b1;
        if (idx_q == last) busy_q <= 1'b0;
      end
    end
  end

  p_pkt_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> dat_o == SYNC);
endmodule

// File: rtl/i2c_pb_bridge.sv
module i2c_pb_bridge
  import i2c_pb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] SYNC     = 8'h79,
  parameter int         DEPTH    = 16,
  parameter int         FILT_LEN = 3,
  parameter int         TIMEOUT  = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       link_lock_i,
  input  logic       ack_gate_i,
  output logic       pkt_valid_o,
  output logic [7:0] pkt_data_o,
  input  logic       rep_valid_i,
  input  logic [7:0] rep_data_i
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_pb_filt #(.LEN(FILT_LEN)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_i(raw[g]), .out_o(filt[g]));
  end

  logic scl_f, sda_f, scl_q, sda_q;
  logic scl_rise, scl_fall, start, stop;
  assign scl_f    = filt[0];
  assign sda_f    = filt[1];
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop     = scl_f & scl_q & ~sda_q & sda_f;

  bus_st_e       st_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q, reg_q;
  logic          ack_ph_q, nak_q, rw_q, mack_q, req_wr_q, req_rd_q;
  logic [TW-1:0] tmo_q;
  logic          ok, acc, fifo_push, fifo_pop, fifo_full;
  logic [CW-1:0] fifo_cnt;
  logic [7:0]    fifo_dout, rd_byte;

  assign ok  = !ack_gate_i || link_lock_i;
  assign acc = ok && ((st_q == ST_ADDR) ? (sh_q[7:1] == DEV_ADDR) :
                      (st_q == ST_WDAT) ? !fifo_full : 1'b1);
  assign fifo_push = (st_q == ST_WDAT) && scl_fall && (cnt_q == 4'd8) &&
                     !ack_ph_q && acc && !start && !stop;
  assign rd_byte   = rep_valid_i ? rep_data_i : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; reg_q <= '0;
      ack_ph_q <= 1'b0; nak_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
      req_wr_q <= 1'b0; req_rd_q <= 1'b0; tmo_q <= '0;
      sda_oe_o <= 1'b0; scl_oe_o <= 1'b0;
    end else begin
      scl_q    <= scl_f;
      sda_q    <= sda_f;
      req_wr_q <= 1'b0;
      req_rd_q <= 1'b0;
      if (start || stop) begin
        if (fifo_cnt != '0) req_wr_q <= 1'b1;
        st_q     <= start ? ST_ADDR : ST_IDLE;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        sda_oe_o <= 1'b0;
        scl_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_REG, ST_WDAT: begin
            if (scl_rise && cnt_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8 && !ack_ph_q) begin
              ack_ph_q <= 1'b1;
              sda_oe_o <= acc;
              nak_q    <= !acc;
              if (st_q == ST_ADDR) rw_q  <= sh_q[0];
              if (st_q == ST_REG)  reg_q <= sh_q;
            end else if (scl_fall && ack_ph_q) begin
              ack_ph_q <= 1'b0;
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              if (nak_q) st_q <= ST_SKIP;
              else if (st_q == ST_ADDR) begin
                if (rw_q) begin
                  st_q     <= ST_RWAIT;
                  scl_oe_o <= 1'b1;
                  req_rd_q <= 1'b1;
                  tmo_q    <= '0;
                end else st_q <= ST_REG;
              end else st_q <= ST_WDAT;
            end
          end
          ST_RWAIT: begin
            if (rep_valid_i || tmo_q == TW'(TIMEOUT - 1)) begin
              sh_q     <= rd_byte;
              sda_oe_o <= ~rd_byte[7];
              scl_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_RDAT;
            end else tmo_q <= tmo_q + 1'b1;
          end
          ST_RDAT: begin
            if (scl_rise && cnt_q == 4'd8) mack_q <= ~sda_f;
            else if (scl_fall) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q < 4'd7) begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end else if (cnt_q == 4'd7) sda_oe_o <= 1'b0;
              else begin
                cnt_q <= '0;
                if (mack_q) begin
                  reg_q    <= reg_q + 1'b1;
                  req_rd_q <= 1'b1;
                  scl_oe_o <= 1'b1;
                  tmo_q    <= '0;
                  st_q     <= ST_RWAIT;
                end else st_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2c_pb_fifo #(.W(8), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(fifo_push), .din_i(sh_q),
    .pop_i(fifo_pop), .dout_o(fifo_dout), .cnt_o(fifo_cnt), .full_o(fifo_full));

  i2c_pb_tx #(.CW(CW), .SYNC(SYNC), .DEV(DEV_ADDR)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_wr_i(req_wr_q), .req_rd_i(req_rd_q),
    .reg_i(reg_q), .cnt_i(fifo_cnt), .fifo_d_i(fifo_dout), .pop_o(fifo_pop),
    .vld_o(pkt_valid_o), .dat_o(pkt_data_o));

  p_sda_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_f));
  p_ack_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && $past(st_q != ST_RWAIT && st_q != ST_RDAT))
      |-> $past(!ack_gate_i || link_lock_i));
  p_stretch_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> st_q == ST_RWAIT);
  p_read_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q == ST_RWAIT && rep_valid_i)) |-> !scl_oe_o);
endmodule

// File: tb/i2c_pb_bridge_tb.sv
module i2c_pb_bridge_tb;
  localparam logic [6:0] DEV  = 7'h48;
  localparam logic [7:0] SYNC = 8'h79;
  localparam int DEPTH = 16;
  localparam int TMO   = 300;
  localparam int Q     = 16;

  typedef struct packed {
    logic [6:0] dev; logic [7:0] rg; logic [4:0] n; logic [7:0] seed;
    logic lock; logic gate; logic ack;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{7'h48, 8'h10, 5'd1, 8'h11, 1'b1, 1'b0, 1'b1},
    '{7'h48, 8'h20, 5'd3, 8'h80, 1'b1, 1'b1, 1'b1},
    '{7'h48, 8'h7F, 5'd2, 8'hF0, 1'b0, 1'b0, 1'b1},
    '{7'h48, 8'h30, 5'd2, 8'h01, 1'b0, 1'b1, 1'b0},
    '{7'h21, 8'h30, 5'd2, 8'h01, 1'b1, 1'b0, 1'b0},
    '{7'h48, 8'hFF, 5'd5, 8'hC0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, lock = 1'b1, gate = 1'b0;
  logic rep_v = 1'b0, glitch = 1'b0, resp_en = 1'b1;
  logic [7:0] rep_d = '0;
  logic scl_oe, sda_oe, pkt_valid;
  logic [7:0] pkt_data;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  i2c_pb_bridge #(.DEV_ADDR(DEV), .SYNC(SYNC), .DEPTH(DEPTH), .FILT_LEN(3),
                  .TIMEOUT(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .link_lock_i(lock),
    .ack_gate_i(gate), .pkt_valid_o(pkt_valid), .pkt_data_o(pkt_data),
    .rep_valid_i(rep_v), .rep_data_i(rep_d));

  int n_chk = 0, n_fail = 0;
  logic [7:0] cap [256];
  int cap_n = 0, rsp_ptr = 0, rsp_dly = 0, r2_bad = 0;
  logic sda_oe_p = 1'b0, scl_bus_p = 1'b1;

  always @(negedge clk) if (pkt_valid && cap_n < 256) begin
    cap[cap_n] <= pkt_data;
    cap_n <= cap_n + 1;
  end

  // remote model: answers each read request with register ^ 8'hA5
  always @(negedge clk) begin
    rep_v <= 1'b0;
    if (rsp_ptr + 4 <= cap_n) begin
      if (cap[rsp_ptr+1][0]) begin
        if (!resp_en) rsp_ptr <= rsp_ptr + 4;
        else if (rsp_dly == 40) begin
          rep_v <= 1'b1; rep_d <= cap[rsp_ptr+2] ^ 8'hA5;
          rsp_ptr <= rsp_ptr + 4; rsp_dly <= 0;
        end else rsp_dly <= rsp_dly + 1;
      end else if (rsp_ptr + 4 + int'(cap[rsp_ptr+3]) <= cap_n)
        rsp_ptr <= rsp_ptr + 4 + int'(cap[rsp_ptr+3]);
    end
  end

  // R2 monitor: SDA enable must not move while the bus SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe != sda_oe_p && scl_bus_p) r2_bad <= r2_bad + 1;
    sda_oe_p  <= sda_oe;
    scl_bus_p <= scl_bus;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hi();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wait_hi(); wq(Q/2);
    if (glitch) begin m_scl = 1'b0; wq(2); m_scl = 1'b1; end
    wq(Q/2);
    r = sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic m_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wait_hi(); wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wait_hi(); wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, r); d = {d[6:0], r}; end
    clk_bit(!mack, r);
  endtask

  initial begin : watchdog
    wq(150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] d;
    int base, exp_len, errs, nack_cnt;
    wq(5); rst_n = 1'b1; wq(5);
    chk(!scl_oe && !sda_oe && !pkt_valid, "R1 reset outputs",
        {scl_oe, sda_oe, pkt_valid}, 0);

    // R3 R4 R5 table of write transfers
    for (int v = 0; v < NV; v++) begin
      lock = VECS[v].lock; gate = VECS[v].gate; base = cap_n;
      m_start();
      wr_byte({VECS[v].dev, 1'b0}, a);
      chk(a == VECS[v].ack, "R3 R4 address ack", a, VECS[v].ack);
      if (a) begin
        wr_byte(VECS[v].rg, a2);
        for (int i = 0; i < VECS[v].n; i++) wr_byte(VECS[v].seed + 8'(i), a2);
      end
      m_stop(); wq(40);
      exp_len = VECS[v].ack ? 4 + int'(VECS[v].n) : 0;
      chk(cap_n - base == exp_len, "R5 packet length", cap_n - base, exp_len);
      if (VECS[v].ack) begin
        errs = 0;
        if (cap[base] != SYNC) errs++;
        if (cap[base+1] != {DEV, 1'b0}) errs++;
        if (cap[base+2] != VECS[v].rg) errs++;
        if (cap[base+3] != 8'(VECS[v].n)) errs++;
        for (int i = 0; i < VECS[v].n; i++)
          if (cap[base+4+i] != VECS[v].seed + 8'(i)) errs++;
        chk(errs == 0, "R5 packet bytes", errs, 0);
      end
    end
    lock = 1'b1; gate = 1'b0;

    // R7 register only
    base = cap_n;
    m_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h55, a); m_stop(); wq(40);
    chk(cap_n == base, "R7 no packet", cap_n - base, 0);

    // R6 overfill
    base = cap_n; nack_cnt = 0;
    m_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h60, a);
    for (int i = 0; i <= DEPTH; i++) begin
      wr_byte(8'(i), a);
      if (!a) nack_cnt++;
      if (i == DEPTH) chk(!a, "R6 extra byte nack", a, 0);
    end
    m_stop(); wq(60);
    chk(nack_cnt == 1, "R6 nack count", nack_cnt, 1);
    chk(cap_n - base == 4 + DEPTH && cap[base+3] == 8'(DEPTH) &&
        cap[base+3+DEPTH] == 8'(DEPTH - 1), "R6 packet", cap[base+3], DEPTH);

    // R8 R9 read with auto-increment
    resp_en = 1'b1; base = cap_n;
    m_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h42, a);
    m_start(); wr_byte({DEV, 1'b1}, a);
    chk(a, "R8 read address ack", a, 1);
    wq(10);
    chk(scl_oe, "R8 SCL stretched", scl_oe, 1);
    rd_byte(1'b1, d);
    chk(d == (8'h42 ^ 8'hA5), "R9 first read byte", d, 8'h42 ^ 8'hA5);
    chk(cap[base] == SYNC && cap[base+1] == {DEV, 1'b1} && cap[base+2] == 8'h42 &&
        cap[base+3] == 8'h01, "R8 read packet", cap[base+2], 8'h42);
    rd_byte(1'b0, d);
    chk(d == (8'h43 ^ 8'hA5), "R9 next register byte", d, 8'h43 ^ 8'hA5);
    m_stop(); wq(40);
    chk(cap_n - base == 8 && cap[base+6] == 8'h43, "R9 second request",
        cap_n - base, 8);

    // R10 no reply
    resp_en = 1'b0;
    m_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h50, a);
    m_start(); wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R10 timeout data", d, 8'hFF);
    chk(!scl_oe, "R10 SCL released", scl_oe, 0);
    m_stop(); wq(40);

    // R11 short SCL dips
    glitch = 1'b1; base = cap_n;
    m_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h33, a); wr_byte(8'h5A, a2);
    glitch = 1'b0;
    m_stop(); wq(40);
    chk(cap_n - base == 5 && cap[base+2] == 8'h33 && cap[base+4] == 8'h5A,
        "R11 glitch ignored", cap[base+4], 8'h5A);

    chk(r2_bad == 0, "R2 SDA change while SCL high", r2_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule